// File: doc/BRIEF.md
# Output Top-of-Frame Timing Generator

This block produces a single top-of-frame pulse for an output video format. A pixel counter and a line counter step on a pixel-rate clock enable, and the frame lengths come from programmable totals for pixels per line and lines per frame. Each counter step is taken on one of two clock enables, a standard-definition one or a high-definition one, and a configuration bit picks which. The pulse polarity can also be set.

The output frame can be locked to an incoming reference frame pulse. Software first sets an alignment enable bit, then writes a rising edge to an init bit. The next reference pulse then reloads the counters, so that the output frame starts a programmed number of lines after that reference pulse. The line offset is signed, so it can delay or advance the frame. Once the reload has happened, or after the enable is cleared, the counters run freely and later reference pulses are ignored. All configuration is held in a small byte-wide register file, written and read through a simple synchronous port.

Top module: `tof_gen`

## Requirements
- R1: After reset every stored field is zero, every register address reads 0x00, and tof_o is inactive (high, because the polarity bit resets to 0).
- R2: Register map, one byte per address. 0: pixels-per-line bits 7:0. 1: bits 4:0 hold pixels-per-line bits 12:8, and bit 5 is the clock select. 2: output lines-per-frame bits 7:0. 3: bits 3:0 hold output lines-per-frame bits 11:8. 4: reference lines-per-frame bits 7:0. 5: bits 3:0 hold reference lines-per-frame bits 11:8. 6: line offset bits 7:0. 7: bits 3:0 hold line offset bits 11:8. 8: control, with bit 0 the alignment enable, bit 1 init and bit 2 polarity. Every other bit, and addresses 9 to 15, read 0 and ignore writes. Reads are combinational from reg_addr_i.
- R3: On each selected clock enable the pixel counter steps, wrapping to 0 after total pixels per line minus one. On that wrap the line counter steps, wrapping to 0 after output lines per frame minus one. If either total is zero the generator is idle and the pulse is never active.
- R4: The pulse is active while both counters are zero, which is exactly one selected-enable period per frame.
- R5: A polarity bit of 1 makes tof_o active high. A polarity bit of 0 makes it active low.
- R6: A clock select of 0 advances the counters on sd_ce_i, and a clock select of 1 advances them on hd_ce_i. The other enable has no effect.
- R7: After an armed init, the first reference pulse loads the pixel counter with 0 and the line counter with (−offset) mod output lines per frame. The offset is read as 12-bit two's complement. The load takes effect at the clock edge where ref_frame_i is high, whatever the clock enables are doing.
- R8: Alignment is armed only by a write to address 8 that sets bit 1 while the stored init bit is 0 and the written bit 0 is 1. Writing 1 over a stored 1, or setting init with the enable at 0, does not arm it.
- R9: Once the armed load has happened, or the enable has been cleared before it, reference pulses do not affect the counters.
- R10: The reference lines-per-frame field is stored and read back on its own, separately from the output lines per frame, and it does not change the output timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sd_ce_i | input | 1 | Standard-definition pixel clock enable |
| hd_ce_i | input | 1 | High-definition pixel clock enable |
| ref_frame_i | input | 1 | Reference frame pulse, one cycle wide |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| tof_o | output | 1 | Top-of-frame pulse, polarity selectable |

## Verification
The hardest case to reach is a stray reference pulse that arrives after alignment is no longer armed. Three routes lead there: a rewrite of 1 over a stored init bit of 1, an init written while the enable is 0, and a clear of the enable after arming. The stimulus gets each of these states through register writes. It then waits until the line counter of the bench model is partway through a frame and sends a reference pulse, set up so that a wrongful reload would show as an immediate frame start. Offsets that are negative or larger than the frame length exercise the modular load value.

// File: rtl/tof_pkg.sv
`timescale 1ns/1ps
package tof_pkg;
  localparam int unsigned PIX_W  = 13;
  localparam int unsigned LIN_W  = 12;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned EXT_W  = LIN_W + 2;

  localparam logic [ADDR_W-1:0] A_PPL_LO = 4'd0;
  localparam logic [ADDR_W-1:0] A_PPL_HI = 4'd1;
  localparam logic [ADDR_W-1:0] A_LPF_LO = 4'd2;
  localparam logic [ADDR_W-1:0] A_LPF_HI = 4'd3;
  localparam logic [ADDR_W-1:0] A_REF_LO = 4'd4;
  localparam logic [ADDR_W-1:0] A_REF_HI = 4'd5;
  localparam logic [ADDR_W-1:0] A_OFF_LO = 4'd6;
  localparam logic [ADDR_W-1:0] A_OFF_HI = 4'd7;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd8;

  localparam int unsigned CTRL_EN   = 0;
  localparam int unsigned CTRL_INIT = 1;
  localparam int unsigned CTRL_POL  = 2;
  localparam int unsigned HI_CLKSEL = 5;

  typedef struct packed {
    logic [PIX_W-1:0] ppl;
    logic [LIN_W-1:0] lpf;
    logic [LIN_W-1:0] ref_lpf;
    logic [LIN_W-1:0] offset;
    logic             clk_sel;
    logic             align_en;
    logic             pol;
  } tof_cfg_t;
endpackage

// File: rtl/tof_regs.sv
`timescale 1ns/1ps
module tof_regs import tof_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output tof_cfg_t          cfg_o,
  output logic              init_pulse_o
);
  logic [PIX_W-1:0] ppl_q;
  logic [LIN_W-1:0] lpf_q, ref_q, off_q;
  logic             clk_sel_q, en_q, init_q, pol_q;
  logic             ctrl_wr;

  assign ctrl_wr = we_i && (addr_i == A_CTRL);
  // arm on 0->1 of the stored init bit, enable taken from the same write
  assign init_pulse_o = ctrl_wr && wdata_i[CTRL_INIT] && !init_q && wdata_i[CTRL_EN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ppl_q     <= '0;
      lpf_q     <= '0;
      ref_q     <= '0;
      off_q     <= '0;
      clk_sel_q <= 1'b0;
      en_q      <= 1'b0;
      init_q    <= 1'b0;
      pol_q     <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        A_PPL_LO: ppl_q[7:0] <= wdata_i;
        A_PPL_HI: begin
          ppl_q[PIX_W-1:8] <= wdata_i[PIX_W-9:0];
          clk_sel_q        <= wdata_i[HI_CLKSEL];
        end
        A_LPF_LO: lpf_q[7:0]       <= wdata_i;
        A_LPF_HI: lpf_q[LIN_W-1:8] <= wdata_i[LIN_W-9:0];
        A_REF_LO: ref_q[7:0]       <= wdata_i;
        A_REF_HI: ref_q[LIN_W-1:8] <= wdata_i[LIN_W-9:0];
        A_OFF_LO: off_q[7:0]       <= wdata_i;
        A_OFF_HI: off_q[LIN_W-1:8] <= wdata_i[LIN_W-9:0];
        A_CTRL: begin
          en_q   <= wdata_i[CTRL_EN];
          init_q <= wdata_i[CTRL_INIT];
          pol_q  <= wdata_i[CTRL_POL];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_PPL_LO: rdata_o = ppl_q[7:0];
      A_PPL_HI: begin
        rdata_o[PIX_W-9:0] = ppl_q[PIX_W-1:8];
        rdata_o[HI_CLKSEL] = clk_sel_q;
      end
      A_LPF_LO: rdata_o = lpf_q[7:0];
      A_LPF_HI: rdata_o[LIN_W-9:0] = lpf_q[LIN_W-1:8];
      A_REF_LO: rdata_o = ref_q[7:0];
      A_REF_HI: rdata_o[LIN_W-9:0] = ref_q[LIN_W-1:8];
      A_OFF_LO: rdata_o = off_q[7:0];
      A_OFF_HI: rdata_o[LIN_W-9:0] = off_q[LIN_W-1:8];
      A_CTRL: begin
        rdata_o[CTRL_EN]   = en_q;
        rdata_o[CTRL_INIT] = init_q;
        rdata_o[CTRL_POL]  = pol_q;
      end
      default: rdata_o = '0;
    endcase
  end

  always_comb begin
    cfg_o.ppl      = ppl_q;
    cfg_o.lpf      = lpf_q;
    cfg_o.ref_lpf  = ref_q;
    cfg_o.offset   = off_q;
    cfg_o.clk_sel  = clk_sel_q;
    cfg_o.align_en = en_q;
    cfg_o.pol      = pol_q;
  end

  p_init_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_pulse_o |=> (init_q && en_q));
endmodule

// File: rtl/tof_align.sv
`timescale 1ns/1ps
module tof_align import tof_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             init_pulse_i,
  input  logic             ref_i,
  input  logic [LIN_W-1:0] offset_i,
  input  logic [LIN_W-1:0] lpf_i,
  output logic             load_o,
  output logic [LIN_W-1:0] line_init_o
);
  logic                    pending_q;
  logic signed [EXT_W-1:0] neg_off;
  logic [EXT_W-1:0]        mag, den, rem, lpf_ext, res;

  assign load_o = pending_q && en_i && ref_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pending_q <= 1'b0;
    else if (init_pulse_i)      pending_q <= 1'b1;
    else if (!en_i || load_o)   pending_q <= 1'b0;
  end

  // line start = (-offset) mod lpf, offset two's complement
  always_comb begin
    neg_off = -EXT_W'($signed(offset_i));
    mag     = neg_off[EXT_W-1] ? EXT_W'(-neg_off) : EXT_W'(neg_off);
    lpf_ext = EXT_W'(lpf_i);
    den     = (lpf_i == '0) ? EXT_W'(1) : lpf_ext;
    rem     = mag % den;
    if (lpf_i == '0)                       res = '0;
    else if (neg_off[EXT_W-1] && rem != '0) res = lpf_ext - rem;
    else                                    res = rem;
    line_init_o = res[LIN_W-1:0];
  end

  p_pending_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !init_pulse_i) |=> !pending_q);
  p_load_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && !init_pulse_i) |=> !load_o);
endmodule

// File: rtl/tof_counter.sv
`timescale 1ns/1ps
module tof_counter import tof_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             load_i,
  input  logic [LIN_W-1:0] line_init_i,
  input  logic [PIX_W-1:0] ppl_i,
  input  logic [LIN_W-1:0] lpf_i,
  output logic             origin_o
);
  logic [PIX_W-1:0] pix_q;
  logic [LIN_W-1:0] line_q;
  logic             pix_last, line_last;

  assign pix_last  = ({1'b0, pix_q}  + (PIX_W+1)'(1)) >= {1'b0, ppl_i};
  assign line_last = ({1'b0, line_q} + (LIN_W+1)'(1)) >= {1'b0, lpf_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q  <= '0;
      line_q <= '0;
    end else if (load_i) begin
      pix_q  <= '0;
      line_q <= line_init_i;
    end else if (adv_i) begin
      if (pix_last) begin
        pix_q  <= '0;
        line_q <= line_last ? '0 : line_q + 1'b1;
      end else begin
        pix_q  <= pix_q + 1'b1;
      end
    end
  end

  assign origin_o = (pix_q == '0) && (line_q == '0);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> ($stable(pix_q) && $stable(line_q)));
  p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (pix_q == '0 && line_q == $past(line_init_i)));
  p_pix_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && pix_last) |=> (pix_q == '0));
endmodule

// File: rtl/tof_gen.sv
`timescale 1ns/1ps
module tof_gen import tof_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sd_ce_i,
  input  logic              hd_ce_i,
  input  logic              ref_frame_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              tof_o
);
  tof_cfg_t         cfg;
  logic             init_pulse, load, adv, origin, active;
  logic [LIN_W-1:0] line_init;

  tof_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (reg_we_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .rdata_o      (reg_rdata_o),
    .cfg_o        (cfg),
    .init_pulse_o (init_pulse)
  );

  tof_align u_align (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (cfg.align_en),
    .init_pulse_i (init_pulse),
    .ref_i        (ref_frame_i),
    .offset_i     (cfg.offset),
    .lpf_i        (cfg.lpf),
    .load_o       (load),
    .line_init_o  (line_init)
  );

  assign adv = cfg.clk_sel ? hd_ce_i : sd_ce_i;

  tof_counter u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (adv),
    .load_i      (load),
    .line_init_i (line_init),
    .ppl_i       (cfg.ppl),
    .lpf_i       (cfg.lpf),
    .origin_o    (origin)
  );

  assign active = origin && (cfg.ppl != '0) && (cfg.lpf != '0);
  assign tof_o  = cfg.pol ? active : !active;

  p_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.ppl == '0) |-> (tof_o == cfg.pol ? 1'b0 : 1'b1));
endmodule

// File: tb/tb_tof_gen.sv
`timescale 1ns/1ps
module tb_tof_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sd_ce_i = 1'b0;
  logic       hd_ce_i = 1'b0;
  logic       ref_frame_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [3:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       tof_o;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0, done = 0;
  int ce_cnt = 0, ce_mode = 0;

  // behavioural model state
  int m_ppl, m_lpf, m_ref, m_off, m_clk, m_en, m_init, m_pol, m_pix, m_line, m_pend;

  tof_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sd_ce_i(sd_ce_i), .hd_ce_i(hd_ce_i),
    .ref_frame_i(ref_frame_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .tof_o(tof_o)
  );

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    #1;
    ce_cnt++;
    hd_ce_i = (ce_mode == 1) ? 1'b0 : (ce_cnt % 2 == 0);
    sd_ce_i = (ce_cnt % 3 == 0);
  end

  always @(posedge clk_i) begin : model
    int ld, so, l0, adv, ip, np, d;
    if (!rst_ni) begin
      m_ppl = 0; m_lpf = 0; m_ref = 0; m_off = 0; m_clk = 0;
      m_en = 0; m_init = 0; m_pol = 0; m_pix = 0; m_line = 0; m_pend = 0;
    end else begin
      d   = reg_wdata_i;
      ld  = m_pend && m_en && ref_frame_i;
      so  = (m_off >= 2048) ? m_off - 4096 : m_off;
      l0  = (m_lpf == 0) ? 0 : (((-so) % m_lpf) + m_lpf) % m_lpf;
      adv = m_clk ? hd_ce_i : sd_ce_i;
      ip  = reg_we_i && reg_addr_i == 8 && d[1] && !m_init && d[0];
      np  = ip ? 1 : ((!m_en || ld) ? 0 : m_pend);
      if (ld) begin
        m_pix = 0; m_line = l0;
      end else if (adv) begin
        if (m_pix + 1 >= m_ppl) begin
          m_pix = 0;
          m_line = (m_line + 1 >= m_lpf) ? 0 : m_line + 1;
        end else m_pix = m_pix + 1;
      end
      m_pend = np;
      if (reg_we_i) case (reg_addr_i)
        0: m_ppl = (m_ppl & 'h1F00) | d;
        1: begin m_ppl = (m_ppl & 'hFF) | ((d & 31) << 8); m_clk = d[5]; end
        2: m_lpf = (m_lpf & 'hF00) | d;
        3: m_lpf = (m_lpf & 'hFF) | ((d & 15) << 8);
        4: m_ref = (m_ref & 'hF00) | d;
        5: m_ref = (m_ref & 'hFF) | ((d & 15) << 8);
        6: m_off = (m_off & 'hF00) | d;
        7: m_off = (m_off & 'hFF) | ((d & 15) << 8);
        8: begin m_en = d[0]; m_init = d[1]; m_pol = d[2]; end
        default: ;
      endcase
    end
  end

  function automatic int exp_rd(int a);
    case (a)
      0: return m_ppl & 255;
      1: return ((m_ppl >> 8) & 31) | (m_clk << 5);
      2: return m_lpf & 255;
      3: return m_lpf >> 8;
      4: return m_ref & 255;
      5: return m_ref >> 8;
      6: return m_off & 255;
      7: return m_off >> 8;
      8: return m_en | (m_init << 1) | (m_pol << 2);
      default: return 0;
    endcase
  endfunction

  function automatic int exp_tof();
    int act;
    act = (m_pix == 0 && m_line == 0 && m_ppl != 0 && m_lpf != 0);
    return m_pol ? act : !act;
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) if (cmp_on && !done) begin
    chk(tof_o, exp_tof(), "R3 R4 R5 R6 tof per-cycle");
    chk(reg_rdata_o, exp_rd(reg_addr_i), "R2 rdata per-cycle");
  end

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic wr(input int a, input int d);
    reg_we_i = 1'b1; reg_addr_i = 4'(a); reg_wdata_i = 8'(d);
    step();
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    reg_addr_i = 4'(a);
    @(negedge clk_i);
    chk(reg_rdata_o, exp, tag);
    step();
  endtask

  task automatic ref_pulse();
    ref_frame_i = 1'b1;
    step();
    ref_frame_i = 1'b0;
  endtask

  task automatic wait_line(input int l);
    while (m_line != l) step();
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int ch, prev;
    rst_ni = 1'b0;
    reg_addr_i = 4'd8;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(tof_o, 1, "R1 reset tof inactive");
    chk(reg_rdata_o, 0, "R1 reset ctrl");
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    cmp_on = 1;
    rd(0, 0, "R1 ppl reset");
    rd(3, 0, "R1 lpf reset");

    // R2 reserved bits and unused addresses
    wr(1, 'hFF); rd(1, 'h3F, "R2 ppl hi mask");
    wr(3, 'hFF); rd(3, 'h0F, "R2 lpf hi mask");
    wr(7, 'hFF); rd(7, 'h0F, "R2 off hi mask");
    wr(8, 'hF8); rd(8, 'h00, "R2 ctrl mask");
    wr(12, 'hA5); rd(12, 'h00, "R2 unused addr");
    // R10 reference field independent
    wr(4, 'h34); wr(5, 'hFA);
    rd(4, 'h34, "R10 ref lo");
    rd(5, 'h0A, "R10 ref hi");
    rd(2, 'h00, "R10 lpf untouched");

    // free run, hd, ppl 5, lpf 4, active high
    wr(0, 5); wr(1, 'h20); wr(2, 4); wr(3, 0); wr(7, 0); wr(8, 'h04);
    repeat (90) step();
    wr(8, 'h00);                       // R5 active low
    repeat (90) step();
    wr(8, 'h04);

    // R6 hd selected but held off: output frozen
    ce_mode = 1;
    step();
    @(negedge clk_i); prev = tof_o;
    for (int i = 0; i < 30; i++) begin
      step(); @(negedge clk_i); chk(tof_o, prev, "R6 hd held");
    end
    step();
    // R6 switch to sd
    wr(1, 'h00);
    ch = 0;
    @(negedge clk_i); prev = tof_o;
    for (int i = 0; i < 80; i++) begin
      step(); @(negedge clk_i);
      if (tof_o != prev) ch++;
      prev = tof_o;
    end
    step();
    chk(ch > 0, 1, "R6 sd advances");
    ce_mode = 0;
    wr(1, 'h20);

    // R3 idle with zero total
    wr(0, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i); chk(tof_o, 0, "R3 idle zero ppl"); step();
    end
    wr(0, 5); wr(2, 6);

    // R7 offset 2 -> line 4 after ref
    wr(6, 2); wr(7, 0); wr(8, 'h05); wr(8, 'h07);
    repeat (5) step();
    ref_pulse();
    @(negedge clk_i); chk(tof_o, 0, "R7 offset 2 not at origin");
    chk(m_line, 4, "R7 model line");
    repeat (40) step();
    // R7 offset -1
    wr(8, 'h05); wr(6, 'hFF); wr(7, 'h0F); wr(8, 'h07);
    repeat (3) step(); ref_pulse();
    repeat (30) step();
    // R7 offset 8 and -8 (beyond lpf)
    wr(8, 'h05); wr(6, 8); wr(7, 0); wr(8, 'h07);
    ref_pulse(); repeat (25) step();
    wr(8, 'h05); wr(6, 'hF8); wr(7, 'h0F); wr(8, 'h07);
    ref_pulse(); repeat (25) step();
    // R7 offset 0 -> origin immediately
    wr(8, 'h05); wr(6, 0); wr(7, 0); wr(8, 'h07);
    wait_line(3);
    ref_pulse();
    @(negedge clk_i); chk(tof_o, 1, "R7 offset 0 origin");
    step();

    // R9 second ref after completed alignment ignored
    wait_line(2);
    ref_pulse();
    @(negedge clk_i); chk(tof_o, 0, "R9 second ref ignored");
    step();

    // R8 rewrite 1 over 1 does not re-arm
    wr(8, 'h07);
    wait_line(2);
    ref_pulse();
    @(negedge clk_i); chk(tof_o, 0, "R8 init 1 over 1");
    step();

    // R8 init with enable 0 does not arm
    wr(8, 'h04); wr(8, 'h06); wr(8, 'h05);
    wait_line(2);
    ref_pulse();
    @(negedge clk_i); chk(tof_o, 0, "R8 init without enable");
    step();

    // R9 enable cleared after arming
    wr(8, 'h05); wr(8, 'h07); wr(8, 'h04);
    wait_line(2);
    ref_pulse();
    @(negedge clk_i); chk(tof_o, 0, "R9 enable cleared");
    step();

    // R8 enable and init in one write arms
    wr(8, 'h04); wr(8, 'h07);
    wait_line(2);
    ref_pulse();
    @(negedge clk_i); chk(tof_o, 1, "R8 combined write arms");
    step();

    repeat (40) step();
    finish_run();
  end
endmodule